// File: doc/BRIEF.md
# Flash Command Mailbox Responder

This block is the device-side end of a register mailbox through which a remote controller operates an on-chip flash array. The controller reaches it over a 32-bit register port, addressed in dwords relative to the mailbox base. It fills a sixteen-dword data window, then writes a command word with the request bit set. The block decodes the command and moves dwords between the data window and a synchronous flash array. It then posts a status word and clears the request bit, which is the signal the controller polls for.

Four commands are handled: read, write, update-authenticate and power-cycle. Authentication is a stub. Its pass or fail result comes from an input pin. A power-cycle command produces a single-cycle pulse on an output pin. A block of flash at a fixed base address serves as the header region for writes that select it.

Top module: `flash_mbox`

## Requirements
- R1: After reset, every readable register returns 0. These are the data window, the command register and the status register.
- R2: Register offsets: 1 to 16 are data dwords 0 to 15, 17 is the command register and 18 is the status register. Offset 0 and offsets above 18 read 0. Writes to offset 18 have no effect.
- R3: Command word fields: bits 31:28 opcode, 27:24 count, 23:2 dword address, bit 1 header select, bit 0 request. For read (opcode 0x2), count 0 moves 16 dwords and counts 1 to 15 move that many. Flash dwords starting at the address land in data dwords 0 upward.
- R4: Write (opcode 0x0) moves count+1 dwords, from data dwords 0 upward, into flash starting at the dword address.
- R5: A write with the header select bit set goes to flash starting at HDR_BASE (default 240), whatever the address field holds.
- R6: The request bit reads 1 while a command runs and reads 0 once it completes. Writes to the command register or to the data window while the request bit is 1 are ignored.
- R7: On completion the status register holds the result code in bits 3:0 and the executed opcode in bits 7:4. Bit 29 is set. All other bits are 0.
- R8: Update-authenticate (opcode 0x1) completes with result code 0 when authPass is 1 and with result code 1 when it is 0.
- R9: Power-cycle (opcode 0x4) completes with result code 0 and drives powerPulse high for exactly one clock cycle.
- R10: Any other opcode completes with result code 3.
- R11: A read or write whose start address plus dword count exceeds the array depth (256 dwords by default) completes with result code 2. It moves no data: the data window and the flash stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Dword offset from the mailbox base |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| authPass | input | 1 | Outcome of the authentication stub |
| powerPulse | output | 1 | One-cycle pulse for a power-cycle command |

## Verification
The hardest case to reach from the ports is a command-register write that arrives while a command is still running. From outside, the block is busy for only about twenty cycles. The bench therefore issues a full sixteen-dword read and, on the very next register access, reads the request bit back as 1. It then writes a power-cycle command at once. The status word still shows the read opcode, and no power pulse appears, which shows the second command was dropped. Out-of-range commands are checked against preloaded data and flash contents, so any dword that moved would show up.

// File: rtl/flash_mbox_pkg.sv
package flash_mbox_pkg;
  localparam int MB_WORDS = 16;
  localparam int MB_IDX_W = $clog2(MB_WORDS);
  localparam int MB_ADDR_W = 22;

  localparam logic [3:0] OP_WRITE = 4'h0;
  localparam logic [3:0] OP_AUTH  = 4'h1;
  localparam logic [3:0] OP_READ  = 4'h2;
  localparam logic [3:0] OP_POWER = 4'h4;

  localparam logic [3:0] RC_OK     = 4'd0;
  localparam logic [3:0] RC_AUTH   = 4'd1;
  localparam logic [3:0] RC_ACCESS = 4'd2;
  localparam logic [3:0] RC_GENERIC = 4'd3;

  typedef struct packed {
    logic                 flashRd;
    logic                 flashWr;
    logic                 finish;
    logic                 pulse;
    logic [MB_ADDR_W-1:0] flashAddr;
    logic [MB_IDX_W-1:0]  dataIdx;
    logic [3:0]           opcode;
    logic [3:0]           code;
  } mbox_strobe_t;
endpackage

// File: rtl/flash_mbox_ctrl.sv
module flash_mbox_ctrl
  import flash_mbox_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int HDR_BASE = 240
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  cmdWord,
  input  logic         authPass,
  output mbox_strobe_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_MOVE, S_FINISH} state_t;
  state_t state;
  logic [MB_IDX_W-1:0] idx;

  logic [3:0] opcode, cntField;
  logic isRd, isWr, inRange;
  logic [MB_IDX_W:0] nWords, lastIdx;
  logic [MB_ADDR_W-1:0] startAddr;

  always_comb begin
    opcode   = cmdWord[31:28];
    cntField = cmdWord[27:24];
    isRd     = (opcode == OP_READ);
    isWr     = (opcode == OP_WRITE);
    if (isRd) nWords = (cntField == 4'd0) ? (MB_IDX_W+1)'(MB_WORDS) : {1'b0, cntField};
    else      nWords = {1'b0, cntField} + 1'b1;
    lastIdx   = nWords - 1'b1;
    startAddr = (isWr && cmdWord[1]) ? MB_ADDR_W'(HDR_BASE) : cmdWord[23:2];
    inRange   = ({1'b0, startAddr} + (MB_ADDR_W+1)'(nWords)) <= (MB_ADDR_W+1)'(DEPTH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        S_IDLE:  if (cmdWord[0]) state <= S_CHECK;
        S_CHECK: begin
          idx   <= '0;
          state <= ((isRd || isWr) && inRange) ? S_MOVE : S_FINISH;
        end
        S_MOVE: begin
          idx <= idx + 1'b1;
          if ({1'b0, idx} == lastIdx) state <= S_FINISH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.opcode    = opcode;
    stb.dataIdx   = idx;
    stb.flashAddr = startAddr + MB_ADDR_W'(idx);
    if (state == S_MOVE) begin
      stb.flashRd = isRd;
      stb.flashWr = isWr;
    end
    if (state == S_FINISH) begin
      stb.finish = 1'b1;
      case (opcode)
        OP_READ, OP_WRITE: stb.code = inRange ? RC_OK : RC_ACCESS;
        OP_AUTH:           stb.code = authPass ? RC_OK : RC_AUTH;
        OP_POWER: begin
          stb.code  = RC_OK;
          stb.pulse = 1'b1;
        end
        default:           stb.code = RC_GENERIC;
      endcase
    end
  end

  // R6
  flash_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.flashRd || stb.flashWr) |-> cmdWord[0]);
endmodule

// File: rtl/flash_mbox_datapath.sv
module flash_mbox_datapath
  import flash_mbox_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         regWrEn,
  input  logic [4:0]   regAddr,
  input  logic [31:0]  regWrData,
  output logic [31:0]  regRdData,
  output logic [31:0]  cmdWord,
  output logic         powerPulse,
  input  mbox_strobe_t stb
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [4:0] OFS_CMD  = 5'(MB_WORDS + 1);
  localparam logic [4:0] OFS_STAT = 5'(MB_WORDS + 2);

  logic [31:0] dataReg [MB_WORDS];
  logic [31:0] statusReg;
  logic [31:0] flashMem [DEPTH];
  logic [31:0] flashQ;
  logic        rdValid;
  logic [MB_IDX_W-1:0] rdIdx;
  logic busy;

  assign busy = cmdWord[0];

  always_ff @(posedge clk) begin
    if (stb.flashWr) flashMem[stb.flashAddr[ADDR_W-1:0]] <= dataReg[stb.dataIdx];
    flashQ <= flashMem[stb.flashAddr[ADDR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdIdx   <= '0;
    end else begin
      rdValid <= stb.flashRd;
      rdIdx   <= stb.dataIdx;
    end
  end

  generate
    for (genvar g = 0; g < MB_WORDS; g++) begin : g_data
      always_ff @(posedge clk) begin
        if (!rst_n) dataReg[g] <= '0;
        else if (rdValid && rdIdx == MB_IDX_W'(g)) dataReg[g] <= flashQ;
        else if (regWrEn && !busy && regAddr == 5'(g + 1)) dataReg[g] <= regWrData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdWord    <= '0;
      statusReg  <= '0;
      powerPulse <= 1'b0;
    end else begin
      powerPulse <= stb.pulse;
      if (stb.finish) begin
        cmdWord[0] <= 1'b0;
        statusReg  <= {2'b00, 1'b1, 21'd0, stb.opcode, stb.code};
      end else if (regWrEn && !busy && regAddr == OFS_CMD) begin
        cmdWord <= regWrData;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr >= 5'd1 && regAddr <= 5'(MB_WORDS)) regRdData = dataReg[4'(regAddr - 5'd1)];
    else if (regAddr == OFS_CMD)  regRdData = cmdWord;
    else if (regAddr == OFS_STAT) regRdData = statusReg;
  end

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stb.finish) |=> $stable(cmdWord));
  // R7
  done_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.finish |=> (!cmdWord[0] && statusReg[29]));
  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    powerPulse |=> !powerPulse);
  // R11
  flash_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.flashRd || stb.flashWr) |-> (stb.flashAddr < MB_ADDR_W'(DEPTH)));
endmodule

// File: rtl/flash_mbox.sv
module flash_mbox
  import flash_mbox_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int HDR_BASE = 240
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [4:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        authPass,
  output logic        powerPulse
);
  mbox_strobe_t stb;
  logic [31:0]  cmdWord;

  flash_mbox_ctrl #(.DEPTH(DEPTH), .HDR_BASE(HDR_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdWord(cmdWord), .authPass(authPass), .stb(stb)
  );

  flash_mbox_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmdWord(cmdWord),
    .powerPulse(powerPulse), .stb(stb)
  );
endmodule

// File: tb/flash_mbox_test.sv
`timescale 1ns/1ps
module flash_mbox_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic authPass = 1'b1;
  logic powerPulse;
  int checks = 0;
  int failures = 0;
  int pulseCycles = 0;

  flash_mbox uut (.clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .authPass(authPass), .powerPulse(powerPulse));

  always #4 clk = ~clk;
  always @(negedge clk) if (powerPulse) pulseCycles++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] mk(logic [3:0] op, logic [3:0] cnt, logic [21:0] ad, logic hdr);
    return {op, cnt, ad, hdr, 1'b1};
  endfunction

  function automatic logic [31:0] st(logic [3:0] op, logic [3:0] code);
    return {2'b00, 1'b1, 21'd0, op, code};
  endfunction

  task automatic run(logic [31:0] cmd, output logic [31:0] status);
    logic [31:0] c;
    wr(5'd17, cmd);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      rd(5'd17, c);
      if (!c[0]) break;
    end
    check("R6 request cleared", {31'd0, c[0]}, 32'd0);
    rd(5'd18, status);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'd1, v);  check("R1 data0", v, 0);
    rd(5'd16, v); check("R1 data15", v, 0);
    rd(5'd17, v); check("R1 cmd", v, 0);
    rd(5'd18, v); check("R1 status", v, 0);
  endtask

  task automatic t_write_read_full();
    logic [31:0] s, v;
    for (int i = 0; i < 16; i++) wr(5'(i + 1), 32'hA500_0000 + i);
    run(mk(4'h0, 4'd15, 22'd0, 1'b0), s);
    check("R4 R7 write status", s, st(4'h0, 4'd0));
    for (int i = 0; i < 16; i++) wr(5'(i + 1), 32'hDEAD_0000);
    run(mk(4'h2, 4'd0, 22'd0, 1'b0), s);
    check("R3 R7 read status", s, st(4'h2, 4'd0));
    for (int i = 0; i < 16; i++) begin
      rd(5'(i + 1), v);
      check("R3 full read data", v, 32'hA500_0000 + i);
    end
  endtask

  task automatic t_partial();
    logic [31:0] s, v;
    for (int i = 0; i < 3; i++) wr(5'(i + 1), 32'h0C00_0000 + i);
    run(mk(4'h0, 4'd2, 22'd20, 1'b0), s);
    check("R4 partial write status", s, st(4'h0, 4'd0));
    for (int i = 0; i < 4; i++) wr(5'(i + 1), 32'h1111_1111);
    run(mk(4'h2, 4'd3, 22'd20, 1'b0), s);
    for (int i = 0; i < 3; i++) begin
      rd(5'(i + 1), v); check("R3 count 3 data", v, 32'h0C00_0000 + i);
    end
    rd(5'd4, v); check("R3 count 3 leaves data3", v, 32'h1111_1111);
  endtask

  task automatic t_header();
    logic [31:0] s, v;
    wr(5'd1, 32'hBEEF_0001); wr(5'd2, 32'hBEEF_0002);
    run(mk(4'h0, 4'd1, 22'd5, 1'b1), s);
    check("R5 header write status", s, st(4'h0, 4'd0));
    run(mk(4'h2, 4'd2, 22'd240, 1'b0), s);
    rd(5'd1, v); check("R5 header dword0", v, 32'hBEEF_0001);
    rd(5'd2, v); check("R5 header dword1", v, 32'hBEEF_0002);
    run(mk(4'h2, 4'd1, 22'd5, 1'b0), s);
    rd(5'd1, v); check("R5 address 5 untouched", v, 32'hA500_0005);
  endtask

  task automatic t_range();
    logic [31:0] s, v;
    wr(5'd1, 32'h5400_0001); wr(5'd2, 32'h5400_0002);
    run(mk(4'h0, 4'd1, 22'd254, 1'b0), s);
    check("R11 in-range edge write", s, st(4'h0, 4'd0));
    wr(5'd1, 32'h7777_7777); wr(5'd2, 32'h7777_7777);
    run(mk(4'h0, 4'd1, 22'd255, 1'b0), s);
    check("R11 write overflow code", s, st(4'h0, 4'd2));
    for (int i = 0; i < 16; i++) wr(5'(i + 1), 32'h3300_0000 + i);
    run(mk(4'h2, 4'd0, 22'd250, 1'b0), s);
    check("R11 read overflow code", s, st(4'h2, 4'd2));
    rd(5'd1, v); check("R11 data kept", v, 32'h3300_0000);
    rd(5'd16, v); check("R11 data kept", v, 32'h3300_000F);
    run(mk(4'h2, 4'd2, 22'd254, 1'b0), s);
    rd(5'd1, v); check("R11 flash kept", v, 32'h5400_0001);
    rd(5'd2, v); check("R11 flash kept", v, 32'h5400_0002);
  endtask

  task automatic t_misc();
    logic [31:0] s;
    int p0;
    authPass = 1'b1;
    run(mk(4'h1, 4'd0, 22'd0, 1'b0), s); check("R8 auth pass", s, st(4'h1, 4'd0));
    authPass = 1'b0;
    run(mk(4'h1, 4'd0, 22'd0, 1'b0), s); check("R8 auth fail", s, st(4'h1, 4'd1));
    authPass = 1'b1;
    p0 = pulseCycles;
    run(mk(4'h4, 4'd0, 22'd0, 1'b0), s);
    repeat (3) @(negedge clk);
    check("R9 power status", s, st(4'h4, 4'd0));
    check("R9 one pulse cycle", pulseCycles - p0, 1);
    run(mk(4'h7, 4'd0, 22'd0, 1'b0), s); check("R10 unknown opcode", s, st(4'h7, 4'd3));
  endtask

  task automatic t_busy();
    logic [31:0] s, v;
    int p0;
    p0 = pulseCycles;
    wr(5'd17, mk(4'h2, 4'd0, 22'd0, 1'b0));
    rd(5'd17, v); check("R6 busy reads 1", {31'd0, v[0]}, 1);
    wr(5'd17, mk(4'h4, 4'd0, 22'd0, 1'b0));
    wr(5'd1, 32'hFFFF_0000);
    run(32'd0, s);
    check("R6 ignored cmd", s, st(4'h2, 4'd0));
    check("R6 no pulse", pulseCycles - p0, 0);
    rd(5'd1, v); check("R6 data write ignored", v, 32'hA500_0000);
  endtask

  task automatic t_regs();
    logic [31:0] v, s0;
    rd(5'd18, s0);
    wr(5'd18, 32'h1234_5678);
    rd(5'd18, v); check("R2 status read-only", v, s0);
    rd(5'd0, v);  check("R2 offset 0", v, 0);
    rd(5'd19, v); check("R2 offset 19", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write_read_full();
    t_partial();
    t_header();
    t_range();
    t_misc();
    t_busy();
    t_regs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule